// File: doc/BRIEF.md
# Parallel Lookahead Decision Network

This block resolves the one-bit decision recursion of a decision feedback equalizer for L symbols in each clock. For every symbol position the upstream arithmetic has already computed all 2^MB possible one-bit decisions, one for each pattern of the MB previous decisions. The network only has to pick the right candidate for each lane. Each pick depends on decisions made earlier in the same block, and for the first lanes of a block also on decisions carried over from the block before.

Each lane first narrows its candidate set with a chain of 2-to-1 multiplexer stages. Each stage halves the set: candidate i is paired with candidate i+N/2, and the older decision between them chooses which one survives. In the straightforward variant every lane uses this tree. The parameter `INCR` selects the incremental variant, in which only lanes 0..MB-1 use the tree. The remaining lanes take their candidate directly, using an index built from the decisions already resolved in the same block. Both variants give the same decision stream.

All L decisions of a block are registered together. The last MB of them become the history for the next block.

Top module: `la_decision_net`

## Requirements
- R1: While rst_n is low, out_valid and out_dec are zero and the carried decision history is cleared to zeros.
- R2: Lane j's candidates sit at in_cand[j*N +: N] with N = 2^MB. Lane j's decision is candidate number idx, where bit k-1 of idx is the decision of the symbol k positions earlier (k = 1..MB), so bit 0 is the immediately preceding decision.
- R3: out_valid is high exactly one clock after a cycle with in_valid high, and out_dec then holds that block's decisions.
- R4: The last MB decisions of a block are used as the earlier decisions for the first lanes of the next valid block, even across idle cycles.
- R5: The incremental variant (INCR=1) and the straightforward variant (INCR=0) give bit-identical out_dec for the same input stream.
- R6: In a cycle without in_valid, out_dec keeps its previous value.
- R7: Lane 0 holds the oldest symbol of a block and lane L-1 the newest, so lane j uses lanes j-1, j-2, … as its preceding decisions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | A block of candidates is present this cycle |
| in_cand | input | L*2^MB | Candidate decisions, N per lane, lane 0 in the low bits |
| out_valid | output | 1 | out_dec holds a new block |
| out_dec | output | L | Resolved decisions, lane 0 in bit 0 |

## Verification
Two things happen in the same cycle when valid blocks arrive back to back. The history from the block just finished feeds the first lanes of the next block. At the same moment, the lanes beyond MB resolve from decisions that were themselves decided in that cycle. The bench provokes this with long bursts of consecutive random blocks and then with bursts broken by idle gaps. Two instances, one per variant, are compared each block against a serial one-symbol-at-a-time model of the recursion.

// File: rtl/la_decision_net.sv
module la_decision_net #(
  parameter int L    = 12,
  parameter int MB   = 3,
  parameter bit INCR = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [L*(1<<MB)-1:0]   in_cand,
  output logic                   out_valid,
  output logic [L-1:0]           out_dec
);
  localparam int N = 1 << MB;

  logic [MB-1:0] hist;
  logic [L-1:0]  dec;

  function automatic logic halve(input logic [N-1:0] c, input logic [MB-1:0] h);
    logic [N-1:0] t;
    t = c;
    for (int s = MB - 1; s >= 0; s--)
      for (int i = 0; i < N / 2; i++)
        if (i < (1 << s))
          t[i] = h[s] ? t[i + (1 << s)] : t[i];
    return t[0];
  endfunction

  always_comb begin
    logic [MB+L-1:0] ext;
    logic [MB-1:0]   h;
    logic [N-1:0]    c;
    ext = '0;
    ext[MB-1:0] = hist;
    dec = '0;
    h = '0;
    c = '0;
    for (int j = 0; j < L; j++) begin
      for (int k = 1; k <= MB; k++)
        h[k-1] = ext[MB+j-k];
      c = in_cand[j*N +: N];
      if (INCR && j >= MB)
        dec[j] = c[h];
      else
        dec[j] = halve(c, h);
      ext[MB+j] = dec[j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist      <= '0;
      out_dec   <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_dec <= dec;
        hist    <= dec[L-1 -: MB];
      end
    end
  end
endmodule

module la_decision_net_chk #(
  parameter int L  = 12,
  parameter int MB = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [L*(1<<MB)-1:0] in_cand,
  input logic                 out_valid,
  input logic [L-1:0]         out_dec
);
  localparam int N = 1 << MB;

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> (!out_valid && out_dec == '0));
  // R3
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid);
  // R3
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid);
  // R6
  hold_dec_chk: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(out_dec));
  // R2
  lane0_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_cand[N-1:0] == '1) |=> out_dec[0]);
  // R2
  lane0_zeros_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_cand[N-1:0] == '0) |=> !out_dec[0]);
endmodule

bind la_decision_net la_decision_net_chk #(.L(L), .MB(MB)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cand(in_cand),
  .out_valid(out_valid), .out_dec(out_dec)
);

// File: tb/la_decision_net_tb.sv
module la_decision_net_tb_top;
  localparam int L  = 12;
  localparam int MB = 3;
  localparam int N  = 1 << MB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [L*N-1:0] in_cand = '0;
  logic out_valid, out_valid_inc;
  logic [L-1:0] out_dec, out_dec_inc;

  int checks = 0;
  int errors = 0;
  logic [L-1:0] expq[$];
  logic [MB-1:0] mhist = '0;
  logic [L-1:0] last_dec = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  la_decision_net #(.L(L), .MB(MB), .INCR(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cand(in_cand),
    .out_valid(out_valid), .out_dec(out_dec));

  la_decision_net #(.L(L), .MB(MB), .INCR(1'b1)) dut_inc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cand(in_cand),
    .out_valid(out_valid_inc), .out_dec(out_dec_inc));

  task automatic check(input string req, input logic [L-1:0] act, input logic [L-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // serial reference: one symbol at a time, lane 0 oldest (R7)
  function automatic logic [L-1:0] model(input logic [L*N-1:0] c);
    logic [L-1:0] r;
    logic [MB-1:0] idx;
    r = '0;
    for (int j = 0; j < L; j++) begin
      idx = mhist;
      r[j] = c[j*N + int'(idx)];
      mhist = {mhist[MB-2:0], r[j]};
    end
    return r;
  endfunction

  task automatic drive(input logic [L*N-1:0] c);
    @(negedge clk);
    in_cand  = c;
    in_valid = 1'b1;
    expq.push_back(model(c));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_cand  = {L*N{1'b1}};
    end
  endtask

  function automatic logic [L*N-1:0] rnd_block();
    logic [L*N-1:0] v;
    for (int i = 0; i < L*N; i += 32) v[i +: 32] = $urandom;
    return v;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    mhist = '0;
    @(negedge clk);
    #1;
    check("R1 out_valid", {{(L-1){1'b0}}, out_valid}, '0);
    check("R1 out_dec", out_dec, '0);
    last_dec = '0;
    rst_n = 1'b1;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (out_valid) begin
          if (expq.size() == 0) begin
            errors++;
            $display("FAIL R3 actual=unexpected out_valid expected=none");
          end else begin
            logic [L-1:0] e;
            e = expq.pop_front();
            check("R2/R4/R7 decisions", out_dec, e);
            check("R5 incremental variant", out_dec_inc, e);
            last_dec = out_dec;
          end
        end else begin
          check("R6 hold", out_dec, last_dec);
          if (expq.size() != 0 && in_valid == 1'b0) begin
            errors++;
            $display("FAIL R3 actual=no out_valid expected=%h", expq[0]);
            void'(expq.pop_front());
          end
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R2: uniform candidate sets
    drive({L*N{1'b1}});
    drive('0);
    // R2: only candidate 0 set per lane; with zero history lane 0 decides 1
    drive({L{{(N-1){1'b0}}, 1'b1}});
    idle(2);
    // R4: history carried across idle gaps
    for (int b = 0; b < 60; b++) begin
      drive(rnd_block());
      if (b % 5 == 4) idle(1 + b % 3);
    end
    idle(2);
    // back-to-back burst
    for (int b = 0; b < 200; b++) drive(rnd_block());
    idle(3);
    // R1: reset mid-stream clears history
    do_reset();
    drive({L{{(N-1){1'b0}}, 1'b1}});
    for (int b = 0; b < 40; b++) drive(rnd_block());
    idle(3);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule